// File: doc/BRIEF.md
# Two-Bank DRAM Strobe Controller with Interleaved Refresh

This block drives a 32 KB dynamic memory built from two 16 KB banks of 16K-by-1 devices. Both banks share the row strobe, the multiplexed address pins and the data wiring. The only thing that separates them is which of the two column strobes fires. Every CPU cycle is split into two slots. The first is a hidden refresh slot: it places a row from a free-running refresh counter on the address pins and pulses the row strobe without any column strobe. The second is the access slot, which carries the CPU's own read or write.

A cycle begins with a one-clock start pulse. On that pulse the block captures the 16-bit CPU address and the write flag. A fast clock then steps each slot through five phases: row setup, row strobe, address switch, column strobe and precharge. In an access slot the row half of the address goes out with the row strobe and the column half with the column strobe. An address in the upper 32 KB of the map gets its refresh slot but no strobe in the access slot, because that part of the map belongs to other devices.

Top module: `dram_strobe_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, and until the next cycle starts, `ras_n`, both `cas_n` bits and `we_n` are high, `rfsh_en` is low and `ma` is zero.
- R2: Each accepted CPU cycle has exactly one refresh row-strobe pulse. During that pulse `rfsh_en` is high, no column strobe is low, and `ma` carries the refresh row.
- R3: The first refresh row after reset is 0. Each accepted cycle advances the row by one, and the row wraps from 127 to 0, so 128 consecutive cycles visit every row once.
- R4: In a lower-half access, `ma` equals `cpu_addr[6:0]` when `ras_n` falls and `cpu_addr[13:7]` when a column strobe falls.
- R5: In a lower-half access (`cpu_addr[15]`=0), exactly one column-strobe pulse occurs. It is on `cas_n[0]` when `cpu_addr[14]`=0 and on `cas_n[1]` when `cpu_addr[14]`=1.
- R6: With `cpu_addr[15]`=1, the cycle has only its refresh row-strobe pulse: no second row pulse and no column pulse.
- R7: A column strobe is low only while `ras_n` is low and falls only after `ras_n` has already been low for at least one clock. All strobes are high again before the next slot starts.
- R8: `we_n` is low only while a column strobe is low in a cycle started with `cpu_wr`=1 (1 = write). Read cycles and refresh slots leave `we_n` high.
- R9: A cycle takes 11 clocks from the accepting edge. A `cyc_start` pulse arriving while a cycle is in progress is ignored: it adds no pulses and does not advance the refresh row.
- R10: Changes to `cpu_addr` and `cpu_wr` after the accepting edge do not affect the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sequencing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse that starts a CPU cycle |
| cpu_addr | input | 16 | CPU address, captured at cycle start |
| cpu_wr | input | 1 | 1 = write, 0 = read, captured at cycle start |
| ma | output | 7 | Multiplexed DRAM address (row, column or refresh row) |
| ras_n | output | 1 | Shared active-low row strobe |
| cas_n | output | 2 | Active-low column strobes, bit 0 lower bank, bit 1 upper bank |
| we_n | output | 1 | Active-low write enable |
| rfsh_en | output | 1 | High while the refresh row drives the address pins |

## Verification
Two things are hard to reach from the ports. One is proving that every one of the 128 refresh rows is visited, because the counter is never visible except on `ma` during a single pulse per cycle. The bench runs a sweep of 256 back-to-back cycles across both bank bits and the upper half, records the row at each refresh fall and checks both the sequence and full coverage. The other is the set of busy-time corners, which only occur mid-cycle: a second start pulse and an address change are injected inside a running cycle. A reset is also forced partway through a cycle, and the next refresh row must restart at zero.

// File: rtl/dram_ctrl_pkg.sv
// Package: shared phase encoding for the DRAM strobe controller.
// Assumes every phase lasts one fast-clock period.
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_RAS   = 3'd2,
        PH_MUX   = 3'd3,
        PH_CAS   = 3'd4,
        PH_PRE   = 3'd5
    } phase_t;

endpackage

// File: rtl/slot_sequencer.sv
// Slot sequencer: steps a refresh slot then an access slot through the
// five phases on each accepted start pulse. Assumes the start pulse is
// only honoured while idle; pulses during a cycle are dropped.
module slot_sequencer
    import dram_ctrl_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cyc_start,
    output phase_t phase,
    output logic   rfsh_slot,
    output logic   accept,
    output logic   rfsh_adv
);

    phase_t phase_q;
    logic   rfsh_q;

    assign phase     = phase_q;
    assign rfsh_slot = rfsh_q;
    assign accept    = (phase_q == PH_IDLE) && cyc_start;
    assign rfsh_adv  = (phase_q == PH_PRE) && rfsh_q;

    // Purpose: advance phase and slot type each fast clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            rfsh_q  <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (cyc_start) begin
                        phase_q <= PH_SETUP;
                        rfsh_q  <= 1'b1;
                    end
                end
                PH_SETUP: phase_q <= PH_RAS;
                PH_RAS:   phase_q <= PH_MUX;
                PH_MUX:   phase_q <= PH_CAS;
                PH_CAS:   phase_q <= PH_PRE;
                PH_PRE: begin
                    if (rfsh_q) begin
                        phase_q <= PH_SETUP;
                        rfsh_q  <= 1'b0;
                    end else begin
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R9: a start pulse in mid-cycle does not restart the sequence.
    a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RAS) |=> (phase_q == PH_MUX));

    // R9: the refresh slot always hands over to the access slot.
    a_r9_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PRE && rfsh_q) |=> (phase_q == PH_SETUP && !rfsh_q));

endmodule

// File: rtl/refresh_counter.sv
// Refresh row counter: free-running row index, advanced once at the end
// of every refresh slot. Assumes ROW_W rows bits cover the device rows.
module refresh_counter #(
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);

    logic [ROW_W-1:0] row_q;

    assign row = row_q;

    // Purpose: step the refresh row, wrapping at 2**ROW_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else if (adv) begin
            row_q <= row_q + ROW_W'(1);
        end
    end

    // R3: the row only moves when a refresh slot completes.
    a_r3_row_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(row_q));

endmodule

// File: rtl/addr_capture.sv
// Address capture: latches the CPU address and write flag on an accepted
// start and splits it into row, column, bank and upper-half fields.
// Assumes AW >= 2*ROW_W + 2 so bank and upper bits sit above the column.
module addr_capture #(
    parameter int AW    = 16,
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [AW-1:0]    cpu_addr,
    input  logic             cpu_wr,
    output logic [ROW_W-1:0] row,
    output logic [ROW_W-1:0] col,
    output logic             bank,
    output logic             upper,
    output logic             wr
);

    localparam int COL_LO   = ROW_W;
    localparam int BANK_BIT = 2 * ROW_W;
    localparam int UPPER_BIT = AW - 1;

    logic [AW-1:0] addr_q;
    logic          wr_q;

    // Purpose: hold the CPU request for the whole cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wr_q   <= 1'b0;
        end else if (accept) begin
            addr_q <= cpu_addr;
            wr_q   <= cpu_wr;
        end
    end

    assign row   = addr_q[ROW_W-1:0];
    assign col   = addr_q[COL_LO +: ROW_W];
    assign bank  = addr_q[BANK_BIT];
    assign upper = addr_q[UPPER_BIT];
    assign wr    = wr_q;

    // R10: the captured request is frozen outside an accepting edge.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(addr_q) && $stable(wr_q)));

endmodule

// File: rtl/strobe_gen.sv
// Strobe generator: decodes phase and slot into registered DRAM strobes,
// the address mux select and write enable. Assumes one bank per column
// strobe and that refresh never drives a column strobe.
module strobe_gen
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W = 7,
    parameter int NBANK = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  phase_t           phase,
    input  logic             rfsh_slot,
    input  logic [ROW_W-1:0] rrow,
    input  logic [ROW_W-1:0] row,
    input  logic [ROW_W-1:0] col,
    input  logic             bank,
    input  logic             upper,
    input  logic             wr,
    output logic [ROW_W-1:0] ma,
    output logic             ras_n,
    output logic [NBANK-1:0] cas_n,
    output logic             we_n,
    output logic             rfsh_en
);

    logic             strobe_ph;
    logic             col_ph;
    logic             active;
    logic             ras_d;
    logic             rfe_d;
    logic [NBANK-1:0] cas_d;
    logic [ROW_W-1:0] ma_d;
    logic             we_d;

    logic [ROW_W-1:0] ma_q;
    logic             ras_q;
    logic [NBANK-1:0] cas_q;
    logic             we_q;
    logic             rfe_q;

    // Purpose: classify the current phase.
    always_comb begin
        strobe_ph = (phase == PH_RAS) || (phase == PH_MUX) || (phase == PH_CAS);
        col_ph    = (phase == PH_MUX) || (phase == PH_CAS);
        active    = (phase != PH_IDLE);
    end

    // Purpose: row strobe and refresh-address gate for the next clock.
    always_comb begin
        ras_d = strobe_ph && (rfsh_slot || !upper);
        rfe_d = rfsh_slot && active && (phase != PH_PRE);
    end

    // Purpose: one column strobe per bank, picked by the bank bit.
    for (genvar b = 0; b < NBANK; b++) begin : g_cas
        assign cas_d[b] = (phase == PH_CAS) && !rfsh_slot && !upper
                          && (bank == b[0]);
    end

    // Purpose: address mux and write enable for the next clock.
    always_comb begin
        if (!active)
            ma_d = '0;
        else if (rfsh_slot)
            ma_d = rrow;
        else if (col_ph)
            ma_d = col;
        else
            ma_d = row;
        we_d = (|cas_d) && wr;
    end

    // Purpose: register all memory-side outputs together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ma_q  <= '0;
            ras_q <= 1'b0;
            cas_q <= '0;
            we_q  <= 1'b0;
            rfe_q <= 1'b0;
        end else begin
            ma_q  <= ma_d;
            ras_q <= ras_d;
            cas_q <= cas_d;
            we_q  <= we_d;
            rfe_q <= rfe_d;
        end
    end

    assign ma      = ma_q;
    assign ras_n   = ~ras_q;
    assign cas_n   = ~cas_q;
    assign we_n    = ~we_q;
    assign rfsh_en = rfe_q;

    // R5: never more than one bank strobe at a time.
    a_r5_one_cas: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cas_q));

    // R7: a column strobe only inside a row strobe.
    a_r7_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
        (|cas_q) |-> ras_q);

    // R7: the row strobe was already low before the column strobe fell.
    a_r7_ras_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cas_q) && !$past(|cas_q)) |-> $past(ras_q));

    // R2: a refresh pulse carries no column strobe.
    a_r2_rfsh_no_cas: assert property (@(posedge clk) disable iff (!rst_n)
        rfe_q |-> (cas_q == '0));

    // R8: write enable only together with a column strobe.
    a_r8_we_with_cas: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> (|cas_q));

endmodule

// File: rtl/dram_strobe_ctrl.sv
// Top: two-bank DRAM strobe controller with one hidden refresh slot and
// one access slot per CPU cycle. Assumes a CPU cycle start pulse no more
// often than the 11-clock cycle length; earlier pulses are dropped.
module dram_strobe_ctrl #(
    parameter int AW    = 16,
    parameter int ROW_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic [AW-1:0]    cpu_addr,
    input  logic             cpu_wr,
    output logic [ROW_W-1:0] ma,
    output logic             ras_n,
    output logic [1:0]       cas_n,
    output logic             we_n,
    output logic             rfsh_en
);

    import dram_ctrl_pkg::*;

    localparam int NBANK = 2;

    phase_t           phase;
    logic             rfsh_slot;
    logic             accept;
    logic             rfsh_adv;
    logic [ROW_W-1:0] rrow;
    logic [ROW_W-1:0] row;
    logic [ROW_W-1:0] col;
    logic             bank;
    logic             upper;
    logic             wr;

    slot_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .phase     (phase),
        .rfsh_slot (rfsh_slot),
        .accept    (accept),
        .rfsh_adv  (rfsh_adv)
    );

    refresh_counter #(.ROW_W(ROW_W)) u_rcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (rfsh_adv),
        .row   (rrow)
    );

    addr_capture #(.AW(AW), .ROW_W(ROW_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .row      (row),
        .col      (col),
        .bank     (bank),
        .upper    (upper),
        .wr       (wr)
    );

    strobe_gen #(.ROW_W(ROW_W), .NBANK(NBANK)) u_stb (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .rfsh_slot (rfsh_slot),
        .rrow      (rrow),
        .row       (row),
        .col       (col),
        .bank      (bank),
        .upper     (upper),
        .wr        (wr),
        .ma        (ma),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .rfsh_en   (rfsh_en)
    );

    // R6: no column strobe ever for an upper-half request.
    a_r6_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        upper |-> (cas_n == 2'b11 || phase == PH_SETUP || phase == PH_IDLE));

endmodule

// File: tb/sim_dram_strobe_ctrl.sv
module sim_dram_strobe_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic [6:0]  ma;
    logic        ras_n;
    logic [1:0]  cas_n;
    logic        we_n;
    logic        rfsh_en;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    dram_strobe_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .ma(ma), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .rfsh_en(rfsh_en)
    );

    // Pulse monitor, sampled on the falling clock edge.
    int         ras_falls, rf_falls, cas0_falls, cas1_falls;
    int         order_bad, we_low, we_bad;
    logic [6:0] rf_row, acc_row, acc_col;
    logic       p_ras = 1'b1;
    logic [1:0] p_cas = 2'b11;
    logic       p_ras_low = 1'b0;

    task automatic clr_mon();
        ras_falls = 0; rf_falls = 0; cas0_falls = 0; cas1_falls = 0;
        order_bad = 0; we_low = 0; we_bad = 0;
        rf_row = '1; acc_row = '1; acc_col = '1;
    endtask

    always @(negedge clk) begin
        if (p_ras && !ras_n) begin
            ras_falls++;
            if (rfsh_en) begin rf_falls++; rf_row = ma; end
            else acc_row = ma;
        end
        if (cas_n != 2'b11 && p_cas == 2'b11) begin
            if (!cas_n[0]) cas0_falls++;
            if (!cas_n[1]) cas1_falls++;
            acc_col = ma;
            if (ras_n || !p_ras_low) order_bad++;
            if (rfsh_en) order_bad++;
        end
        if (!we_n) begin
            we_low++;
            if (cas_n == 2'b11) we_bad++;
        end
        p_ras_low = !ras_n && !p_ras;
        p_ras = ras_n;
        p_cas = cas_n;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    int exp_rrow = 0;
    bit seen [128];

    // Issue one start pulse with optional mid-cycle disturbance.
    task automatic run_cycle(input logic [15:0] a, input logic w,
                             input bit disturb);
        @(negedge clk);
        clr_mon();
        cpu_addr = a; cpu_wr = w; cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        if (disturb) begin
            repeat (2) @(negedge clk);
            cpu_addr = a ^ 16'h7FFF; cpu_wr = ~w; cyc_start = 1'b1;
            @(negedge clk);
            cyc_start = 1'b0;
            repeat (8) @(negedge clk);
        end else begin
            repeat (11) @(negedge clk);
        end
    endtask

    // Compare one finished cycle with the expected pulse pattern.
    task automatic check_cycle(input logic [15:0] a, input logic w);
        bit up = a[15];
        chk(rf_falls == 1, "R2 refresh pulses", rf_falls, 1);
        chk(rf_row == exp_rrow[6:0], "R3 refresh row", rf_row, exp_rrow);
        seen[exp_rrow[6:0]] = 1'b1;
        exp_rrow = (exp_rrow + 1) % 128;
        chk(order_bad == 0, "R7 strobe order", order_bad, 0);
        chk(we_bad == 0, "R8 we without cas", we_bad, 0);
        if (up) begin
            chk(ras_falls == 1, "R6 ras count upper", ras_falls, 1);
            chk(cas0_falls + cas1_falls == 0, "R6 cas upper",
                cas0_falls + cas1_falls, 0);
            chk(we_low == 0, "R8 we upper", we_low, 0);
        end else begin
            chk(ras_falls == 2, "R5 ras count", ras_falls, 2);
            chk(cas0_falls == (a[14] ? 0 : 1), "R5 cas0", cas0_falls, a[14] ? 0 : 1);
            chk(cas1_falls == (a[14] ? 1 : 0), "R5 cas1", cas1_falls, a[14] ? 1 : 0);
            chk(acc_row == a[6:0], "R4 row half", acc_row, a[6:0]);
            chk(acc_col == a[13:7], "R4 col half", acc_col, a[13:7]);
            chk((we_low > 0) == w, "R8 we follows flag", we_low, w);
        end
    endtask

    localparam logic [16:0] VEC [8] = '{
        {1'b0, 16'h0000}, {1'b1, 16'h0000}, {1'b0, 16'h4000},
        {1'b1, 16'h7FFF}, {1'b0, 16'h3F80}, {1'b1, 16'h407F},
        {1'b0, 16'h8000}, {1'b1, 16'hC123}
    };

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        clr_mon();
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(ras_n && cas_n == 2'b11 && we_n && !rfsh_en && ma == 0,
            "R1 reset outputs", {ras_n, cas_n, we_n, rfsh_en}, 5'b11110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ras_n && cas_n == 2'b11 && !rfsh_en, "R1 idle after reset",
            {ras_n, cas_n, rfsh_en}, 4'b1110);

        // Table walk: bank bits, upper half, read and write.
        foreach (VEC[i]) begin
            run_cycle(VEC[i][15:0], VEC[i][16], 1'b0);
            check_cycle(VEC[i][15:0], VEC[i][16]);
        end

        // R9 and R10: second start and address change during a cycle.
        run_cycle(16'h2A55, 1'b0, 1'b1);
        check_cycle(16'h2A55, 1'b0);
        chk(ras_falls == 2, "R9 second start ignored", ras_falls, 2);
        run_cycle(16'h1234, 1'b1, 1'b0);
        check_cycle(16'h1234, 1'b1);   // R9: row advanced only once

        // R3: long sweep, every row visited, wrap past 127.
        foreach (seen[k]) seen[k] = 1'b0;
        for (int i = 0; i < 256; i++) begin
            logic [15:0] a = 16'(i * 16'h0283) ^ 16'(i << 14);
            run_cycle(a, i[0], 1'b0);
            check_cycle(a, i[0]);
        end
        begin
            int cov = 0;
            foreach (seen[k]) if (seen[k]) cov++;
            chk(cov == 128, "R3 all rows visited", cov, 128);
        end

        // R1 and R3: reset in mid-cycle, row restarts at 0.
        @(negedge clk);
        cpu_addr = 16'h0101; cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ras_n && cas_n == 2'b11 && !rfsh_en, "R1 mid-cycle reset",
            {ras_n, cas_n, rfsh_en}, 4'b1110);
        rst_n = 1'b1;
        exp_rrow = 0;
        repeat (2) @(negedge clk);
        run_cycle(16'h5555, 1'b0, 1'b0);
        check_cycle(16'h5555, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule